// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small 8-bit CPU core and decides which interrupt the core services next. Twelve maskable sources feed it. Three are external pins with a selectable active edge. Nine are single-cycle event pulses from elsewhere on the chip: a display-done event, four timer overflows, a slow prescaler tick, a vertical sync event, a serial port and a two-wire bus port. Each maskable source has a request latch and an enable bit. Reset and a software break are handled as non-maskable causes without latches.

The controller compares the enabled pending requests against the CPU's global disable flag and picks the winner on a fixed ladder. It drives the winner's 16-bit vector address. When the CPU acknowledges, the controller clears the winning request and sends a one-cycle pulse that asks the CPU to set its disable flag. Software reaches the request, enable and polarity bits through a small register port. A write to that port can clear a request but can never create one.

Top module: `vec_prio_intc`

## Requirements
- R1: After reset the block reports a pending reset cause with vector FFFE (hex), regardless of the disable flag. All request, enable and polarity bits read 0. The first acknowledge retires the reset cause.
- R2: Maskable sources rank, from highest to lowest: display-done, INT2, INT1, timer 4, prescaler tick, vertical sync, timer 3, timer 2, timer 1, serial, two-wire bus, INT3. Source index k runs from 0 to 11 in that order.
- R3: The maskable vectors for index 0 to 11 are FFFC, FFFA, FFF8, FFF4, FFF2, FFF0, FFEE, FFEC, FFEA, FFE8, FFE6 and FFE4. When nothing is pending the vector output is 0000.
- R4: A maskable source is taken only when its request bit is 1, its enable bit is 1 and the disable flag input is 0.
- R5: An acknowledge while `irq_pending` is high clears the request of the source shown in that cycle and raises `set_iflag` in that same cycle.
- R6: Writing a request register clears each bit written as 0 and leaves each bit written as 1 unchanged. Enable bits take the written value.
- R7: Each external pin has a polarity bit: 0 selects the rising edge and 1 the falling edge. An edge on the pin sets the request 3 clock edges after the pin changes. An edge of the opposite direction has no effect.
- R8: The software break input is non-maskable and ranks lowest. While it is high and nothing above it is pending, the vector is FFDE. An acknowledge of the break clears no request.
- R9: When a source's set and a software clear of the same bit land in one cycle, the bit ends up 1.
- R10: The register map is as follows. Address 0 holds requests k0..k7 in bits 0..7. Address 1 holds requests k8..k11 in bits 0..3. Addresses 2 and 3 hold the enables in the same layout. Address 4 holds the polarity bits for INT1, INT2 and INT3 in bits 0, 1 and 2. Unused bits read 0.
- R11: An internal event pulse sets its request at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| xpin | input | 3 | External pins INT1, INT2, INT3 (bits 0..2) |
| ev_disp | input | 1 | Display-done event pulse |
| ev_tmr | input | 4 | Timer overflow pulses, bit n = timer n+1 |
| ev_tick | input | 1 | Prescaler tick pulse |
| ev_vsync | input | 1 | Vertical sync event pulse |
| ev_sio | input | 1 | Serial port event pulse |
| ev_twi | input | 1 | Two-wire bus event pulse |
| brk_req | input | 1 | Software break request, held until acknowledged |
| cpu_iflag | input | 1 | CPU global interrupt disable flag |
| irq_ack | input | 1 | CPU accepts the presented vector |
| irq_pending | output | 1 | An interrupt awaits service |
| irq_vector | output | 16 | Vector address of the winner |
| set_iflag | output | 1 | Pulse asking the CPU to set its disable flag |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, same cycle |

## Verification
The assertions assume that the CPU raises `irq_ack` only while `irq_pending` is high and for a single cycle, and that it holds `brk_req` until that break is acknowledged. They also assume that `cpu_iflag` changes only between acknowledges, and that each event input is a one-cycle pulse. The stimulus drives every input at the falling clock edge. It raises acknowledge for exactly one cycle, and only after it has checked that a request is pending. It moves pins only between register writes, and it holds each pin level long enough for the synchronizer to see it.

// File: rtl/vec_prio_intc.sv
module vec_prio_intc #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  xpin,
  input  logic        ev_disp,
  input  logic [3:0]  ev_tmr,
  input  logic        ev_tick,
  input  logic        ev_vsync,
  input  logic        ev_sio,
  input  logic        ev_twi,
  input  logic        brk_req,
  input  logic        cpu_iflag,
  input  logic        irq_ack,
  output logic        irq_pending,
  output logic [15:0] irq_vector,
  output logic        set_iflag,
  input  logic [2:0]  reg_addr,
  input  logic        reg_we,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata
);
  localparam int NSRC = 12;
  localparam int HI_W = NSRC - 8;

  logic [2:0]      sync_q [SYNC_STAGES];
  logic [2:0]      prev_q, pol_q, pin_now, pin_edge;
  logic [NSRC-1:0] req_q, en_q, set_vec, act, sw_clr, ack_clr;
  logic            rst_pend_q, sel_hit, take_mask, take;
  logic [3:0]      sel_idx;

  function automatic logic [15:0] vec_of(input logic [3:0] i);
    case (i)
      4'd0:    return 16'hFFFC;
      4'd1:    return 16'hFFFA;
      4'd2:    return 16'hFFF8;
      4'd3:    return 16'hFFF4;
      4'd4:    return 16'hFFF2;
      4'd5:    return 16'hFFF0;
      4'd6:    return 16'hFFEE;
      4'd7:    return 16'hFFEC;
      4'd8:    return 16'hFFEA;
      4'd9:    return 16'hFFE8;
      4'd10:   return 16'hFFE6;
      default: return 16'hFFE4;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= xpin;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign pin_now  = sync_q[SYNC_STAGES-1];
  assign pin_edge = (~pol_q & pin_now & ~prev_q) | (pol_q & ~pin_now & prev_q);

  assign set_vec = {pin_edge[2], ev_twi, ev_sio, ev_tmr[0], ev_tmr[1], ev_tmr[2],
                    ev_vsync, ev_tick, ev_tmr[3], pin_edge[0], pin_edge[1], ev_disp};

  assign act = req_q & en_q;

  always_comb begin
    sel_idx = '0;
    sel_hit = 1'b0;
    for (int k = NSRC-1; k >= 0; k--)
      if (act[k]) begin
        sel_idx = 4'(k);
        sel_hit = 1'b1;
      end
  end

  assign take_mask   = !rst_pend_q && sel_hit && !cpu_iflag;
  assign irq_pending = rst_pend_q || take_mask || brk_req;
  assign irq_vector  = rst_pend_q ? 16'hFFFE :
                       take_mask  ? vec_of(sel_idx) :
                       brk_req    ? 16'hFFDE : 16'h0000;
  assign take        = irq_ack && irq_pending;
  assign set_iflag   = take;
  assign ack_clr     = (take && take_mask) ? (NSRC'(1) << sel_idx) : '0;

  always_comb begin
    sw_clr = '0;
    if (reg_we && reg_addr == 3'd0) sw_clr[7:0]      = ~reg_wdata;
    if (reg_we && reg_addr == 3'd1) sw_clr[NSRC-1:8] = ~reg_wdata[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q      <= '0;
      en_q       <= '0;
      pol_q      <= '0;
      rst_pend_q <= 1'b1;
    end else begin
      req_q <= (req_q & ~sw_clr & ~ack_clr) | set_vec;
      if (reg_we && reg_addr == 3'd2) en_q[7:0]      <= reg_wdata;
      if (reg_we && reg_addr == 3'd3) en_q[NSRC-1:8] <= reg_wdata[HI_W-1:0];
      if (reg_we && reg_addr == 3'd4) pol_q          <= reg_wdata[2:0];
      if (take) rst_pend_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = req_q[7:0];
      3'd1:    reg_rdata = {{(8-HI_W){1'b0}}, req_q[NSRC-1:8]};
      3'd2:    reg_rdata = en_q[7:0];
      3'd3:    reg_rdata = {{(8-HI_W){1'b0}}, en_q[NSRC-1:8]};
      3'd4:    reg_rdata = {5'b0, pol_q};
      default: reg_rdata = 8'h00;
    endcase
  end

  assert_reset_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pend_q |-> (irq_pending && irq_vector == 16'hFFFE));

  assert_vec_form_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (irq_vector[15:8] == 8'hFF && irq_vector[0] == 1'b0));

  assert_mask_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_iflag && !rst_pend_q && !brk_req) |-> !irq_pending);

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_mask && !set_vec[sel_idx]) |=> !req_q[$past(sel_idx)]);

  assert_grant_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_clr));

  assert_no_sw_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_q & ~$past(req_q) & ~$past(set_vec)) == '0));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((req_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: tb/vec_prio_intc_test.sv
module vec_prio_intc_test;
  logic clk = 0, rst_n = 0;
  logic [2:0] xpin = 0;
  logic ev_disp = 0, ev_tick = 0, ev_vsync = 0, ev_sio = 0, ev_twi = 0;
  logic [3:0] ev_tmr = 0;
  logic brk_req = 0, cpu_iflag = 0, irq_ack = 0;
  logic irq_pending, set_iflag;
  logic [15:0] irq_vector;
  logic [2:0] reg_addr = 0;
  logic reg_we = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  vec_prio_intc uut (.*);

  always #2 clk = ~clk;

  // {enable[11:0], event[11:0], iflag, pending, vector}
  localparam logic [41:0] TBL [10] = '{
    {12'hFFF, 12'h001, 1'b0, 1'b1, 16'hFFFC},
    {12'hFFF, 12'h0F8, 1'b0, 1'b1, 16'hFFF4},
    {12'hFF7, 12'h0F8, 1'b0, 1'b1, 16'hFFF2},
    {12'hFE0, 12'h7E0, 1'b0, 1'b1, 16'hFFF0},
    {12'h600, 12'h600, 1'b0, 1'b1, 16'hFFE8},
    {12'hFFF, 12'h7F9, 1'b1, 1'b0, 16'h0000},
    {12'h000, 12'h7F9, 1'b0, 1'b0, 16'h0000},
    {12'h0C0, 12'h1C0, 1'b0, 1'b1, 16'hFFEE},
    {12'h300, 12'h300, 1'b0, 1'b1, 16'hFFEA},
    {12'h600, 12'h400, 1'b0, 1'b1, 16'hFFE6}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [11:0] m);
    @(negedge clk);
    ev_disp = m[0]; ev_tmr = {m[3], m[6], m[7], m[8]};
    ev_tick = m[4]; ev_vsync = m[5]; ev_sio = m[9]; ev_twi = m[10];
    @(negedge clk);
    ev_disp = 0; ev_tmr = 0; ev_tick = 0; ev_vsync = 0; ev_sio = 0; ev_twi = 0;
  endtask

  task automatic clear_all();
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic set_en(input logic [11:0] e);
    wr(3'd2, e[7:0]);
    wr(3'd3, {4'h0, e[11:8]});
  endtask

  task automatic do_ack();
    @(negedge clk);
    irq_ack = 1;
    #1 check("R5 set_iflag during ack", {31'b0, set_iflag}, 32'd1);
    @(negedge clk);
    irq_ack = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [11:0] act, win, got;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 reset pending", {31'b0, irq_pending}, 32'd1);
    check("R1 reset vector", {16'b0, irq_vector}, 32'hFFFE);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      check("R1 R10 register reset value", {24'b0, d}, 32'h0);
    end
    cpu_iflag = 1;
    #1 check("R1 reset ignores disable flag", {16'b0, irq_vector}, 32'hFFFE);
    do_ack();
    #1 check("R1 reset retired by ack", {31'b0, irq_pending}, 32'd0);
    cpu_iflag = 0;

    for (int i = 0; i < 10; i++) begin
      clear_all();
      set_en(TBL[i][41:30]);
      cpu_iflag = TBL[i][17];
      pulse(TBL[i][29:18]);
      #1;
      check("R2 R4 R11 table pending", {31'b0, irq_pending}, {31'b0, TBL[i][16]});
      check("R2 R3 table vector", {16'b0, irq_vector}, {16'b0, TBL[i][15:0]});
      if (TBL[i][16]) begin
        act = TBL[i][29:18] & TBL[i][41:30];
        win = act & (~act + 12'd1);
        do_ack();
        rd(3'd0, d); got[7:0] = d;
        rd(3'd1, d); got[11:8] = d[3:0];
        check("R5 ack clears winner only", {20'b0, got}, {20'b0, TBL[i][29:18] & ~win});
      end
      cpu_iflag = 0;
    end

    // R6 / R10: write-one has no effect, write-zero clears, enables free
    clear_all();
    set_en(12'hFFF);
    pulse(12'h009);
    wr(3'd0, 8'hFF);
    rd(3'd0, d); check("R6 write 1 leaves requests", {24'b0, d}, 32'h09);
    wr(3'd0, 8'hFE);
    rd(3'd0, d); check("R6 write 0 clears bit", {24'b0, d}, 32'h08);
    wr(3'd2, 8'hA5);
    rd(3'd2, d); check("R6 enable readback", {24'b0, d}, 32'hA5);
    wr(3'd3, 8'hFF);
    rd(3'd3, d); check("R10 upper enable bits read 0", {24'b0, d}, 32'h0F);
    wr(3'd4, 8'hFF);
    rd(3'd4, d); check("R10 polarity width", {24'b0, d}, 32'h07);
    wr(3'd4, 8'h00);
    wr(3'd1, 8'hFF);
    rd(3'd1, d); check("R10 R6 request high reg", {24'b0, d}, 32'h00);

    // R9: set and clear collide
    clear_all();
    @(negedge clk);
    ev_disp = 1; reg_addr = 0; reg_wdata = 8'h00; reg_we = 1;
    @(negedge clk);
    ev_disp = 0; reg_we = 0;
    rd(3'd0, d); check("R9 set beats clear", {31'b0, d[0]}, 32'd1);

    // R7: INT1 edges and latency
    clear_all();
    @(negedge clk); xpin[0] = 1;
    @(negedge clk);
    @(negedge clk);
    rd(3'd0, d); check("R7 not set before third edge", {31'b0, d[2]}, 32'd0);
    @(negedge clk);
    rd(3'd0, d); check("R7 INT1 rising sets", {31'b0, d[2]}, 32'd1);
    clear_all();
    @(negedge clk); xpin[0] = 0;
    repeat (4) @(negedge clk);
    rd(3'd0, d); check("R7 INT1 falling ignored at pol 0", {31'b0, d[2]}, 32'd0);
    wr(3'd4, 8'h07);
    @(negedge clk); xpin = 3'b011;
    repeat (4) @(negedge clk);
    rd(3'd0, d); check("R7 rising ignored at pol 1", {30'b0, d[2:1]}, 32'd0);
    @(negedge clk); xpin = 3'b000;
    repeat (4) @(negedge clk);
    rd(3'd0, d); check("R7 INT1 INT2 falling set", {30'b0, d[2:1]}, 32'd3);
    wr(3'd4, 8'h00);

    // R2 / R8: INT3 lowest maskable, break lowest overall
    clear_all();
    set_en(12'hFFF);
    pulse(12'h400);
    @(negedge clk); xpin[2] = 1;
    repeat (4) @(negedge clk);
    #1 check("R2 two-wire above INT3", {16'b0, irq_vector}, 32'hFFE6);
    set_en(12'h800);
    #1 check("R2 R3 INT3 vector", {16'b0, irq_vector}, 32'hFFE4);
    brk_req = 1;
    #1 check("R8 maskable above break", {16'b0, irq_vector}, 32'hFFE4);
    cpu_iflag = 1;
    #1 check("R8 break ignores disable flag", {16'b0, irq_vector}, 32'hFFDE);
    do_ack();
    brk_req = 0;
    rd(3'd1, d); check("R8 break ack keeps requests", {24'b0, d}, 32'h0C);
    #1 check("R4 disable flag masks", {31'b0, irq_pending}, 32'd0);
    cpu_iflag = 0;
    #1 check("R4 unmasked again", {16'b0, irq_vector}, 32'hFFE4);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule